// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This block is the integer multiply and divide engine of a 32-bit RISC core. It keeps a 64-bit accumulator made of two 32-bit halves, HI (upper) and LO (lower). The pipeline hands it a decoded function code, a group select and two 32-bit operands with a one-cycle start strobe. Multiplies, multiply-accumulates and moves into HI/LO finish in the cycle after the strobe. Divides run a 32-step restoring sequence under a busy/done handshake.

Reads of HI or LO, and the three-operand multiply that targets a general register, return a 32-bit value with a one-cycle valid pulse. If a read arrives while a divide is running, it is parked and answered once the divide has written its result. Every other strobe that arrives during a divide is dropped.

Top module: `muldiv_hilo`

## Requirements
- R1: After reset, HI and LO are zero, and busy, done and resValid are low.
- R2: Group 0 code 0x18 (signed) and 0x19 (unsigned) write the 64-bit product of opA and opB: bits 63:32 go to HI and bits 31:0 go to LO.
- R3: Group 1 codes 0x00 (signed) and 0x01 (unsigned) add the product to {HI,LO}. Codes 0x04 (signed) and 0x05 (unsigned) subtract the product from {HI,LO}. Both wrap modulo 2^64.
- R4: Group 1 code 0x02 drives resValid for exactly the cycle after the strobe, with result equal to bits 31:0 of the signed product. HI and LO keep their values.
- R5: Group 0 code 0x11 copies opA into HI and code 0x13 copies opA into LO. The other half is left unchanged.
- R6: Group 0 code 0x10 (HI) and code 0x12 (LO) drive resValid for exactly the cycle after the strobe, with result equal to the selected half.
- R7: Group 0 codes 0x1A (signed) and 0x1B (unsigned) hold busy high for 32 cycles after the strobe. In the cycle after those 32, done is high for one cycle, busy is low, HI holds the remainder and LO holds the quotient.
- R8: A signed quotient truncates toward zero, and the remainder takes the sign of the dividend. The case -2^31 / -1 gives quotient 0x80000000 and remainder 0.
- R9: A zero divisor leaves both HI and LO equal to zero when done rises.
- R10: A read of HI or LO strobed while busy is high is answered with resValid in the cycle after done. The value returned is the one the divide wrote.
- R11: A non-read strobe while busy is high, any strobe while a read is parked, and any undefined code are all ignored. HI, LO and resValid are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle operation strobe |
| opGroup | input | 1 | Code group: 0 = primary, 1 = secondary |
| funct | input | 6 | Function code within the group |
| opA | input | 32 | First operand (dividend, multiplicand, move source) |
| opB | input | 32 | Second operand (divisor, multiplier) |
| busy | output | 1 | Divide sequence in progress |
| done | output | 1 | One-cycle pulse when a divide has written HI/LO |
| resValid | output | 1 | One-cycle pulse qualifying result |
| result | output | 32 | HI/LO read data or low half of a three-operand multiply |

## Verification
HI/LO writes from multiplies and moves land on the first clock edge after the strobe. They are observed with a read, and its resValid pulse arrives in the cycle after the read strobe. The bench drives on falling edges and samples on the falling edge that follows each rising edge, so every check lines up with a known count of edges. For a divide the bench counts busy-high cycles until done appears, and expects exactly 32. A read parked during a divide is expected one cycle after done, never at done itself.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  typedef enum logic [3:0] {
    OP_NONE, OP_RDHI, OP_RDLO, OP_WRHI, OP_WRLO,
    OP_MULT, OP_MADD, OP_MSUB, OP_MUL3, OP_DIV
  } mduOp_e;

  // strobes from control to datapath
  typedef struct packed {
    mduOp_e op;
    logic   isSigned;
    logic   divStep;
    logic   divLast;
  } mduCtl_t;

  localparam int FUNCT_W = 6;
endpackage

// File: rtl/mdu_ctrl.sv
module mdu_ctrl
  import mdu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               opGroup,
  input  logic [FUNCT_W-1:0] funct,
  output mduCtl_t            ctl,
  output logic               busy,
  output logic               done
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(DATA_W - 1);

  mduOp_e decOp;
  logic   decSigned;
  logic   busyQ, doneQ, pendQ, pendHiQ;
  logic [CNT_W-1:0] cntQ;
  logic   accept, park, lastStep;

  always_comb begin
    decOp = OP_NONE;
    decSigned = 1'b0;
    case ({opGroup, funct})
      {1'b0, 6'h10}: decOp = OP_RDHI;
      {1'b0, 6'h11}: decOp = OP_WRHI;
      {1'b0, 6'h12}: decOp = OP_RDLO;
      {1'b0, 6'h13}: decOp = OP_WRLO;
      {1'b0, 6'h18}: begin decOp = OP_MULT; decSigned = 1'b1; end
      {1'b0, 6'h19}: decOp = OP_MULT;
      {1'b0, 6'h1A}: begin decOp = OP_DIV; decSigned = 1'b1; end
      {1'b0, 6'h1B}: decOp = OP_DIV;
      {1'b1, 6'h00}: begin decOp = OP_MADD; decSigned = 1'b1; end
      {1'b1, 6'h01}: decOp = OP_MADD;
      {1'b1, 6'h02}: begin decOp = OP_MUL3; decSigned = 1'b1; end
      {1'b1, 6'h04}: begin decOp = OP_MSUB; decSigned = 1'b1; end
      {1'b1, 6'h05}: decOp = OP_MSUB;
      default: ;
    endcase
  end

  assign accept   = start && !busyQ && !pendQ;
  assign park     = start && busyQ && !pendQ && (decOp == OP_RDHI || decOp == OP_RDLO);
  assign lastStep = busyQ && (cntQ == LAST_STEP);

  always_comb begin
    ctl.op       = OP_NONE;
    ctl.isSigned = decSigned;
    ctl.divStep  = busyQ;
    ctl.divLast  = lastStep;
    if (pendQ && !busyQ) ctl.op = pendHiQ ? OP_RDHI : OP_RDLO;
    else if (accept)     ctl.op = decOp;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0; doneQ <= 1'b0; pendQ <= 1'b0; pendHiQ <= 1'b0;
      cntQ  <= '0;
    end else begin
      doneQ <= lastStep;
      if (accept && decOp == OP_DIV) begin
        busyQ <= 1'b1;
        cntQ  <= '0;
      end else if (busyQ) begin
        cntQ <= cntQ + 1'b1;
        if (lastStep) busyQ <= 1'b0;
      end
      if (park) begin
        pendQ   <= 1'b1;
        pendHiQ <= (decOp == OP_RDHI);
      end else if (pendQ && !busyQ) begin
        pendQ <= 1'b0;
      end
    end
  end

  assign busy = busyQ;
  assign done = doneQ;

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);
  assert_busy_ends_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyQ) |-> doneQ);
  assert_parked_read_served_R10: assert property (@(posedge clk) disable iff (!rstN)
    (pendQ && !busyQ) |=> !pendQ);
endmodule

// File: rtl/mdu_datapath.sv
module mdu_datapath
  import mdu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  mduCtl_t           ctl,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic              resValid,
  output logic [DATA_W-1:0] result
);
  localparam int PROD_W = 2 * DATA_W;

  logic [DATA_W-1:0] hiQ, loQ, remQ, quoQ, dvsQ, resQ;
  logic              resVldQ, negQuoQ, negRemQ, zeroQ;
  logic [PROD_W-1:0] extA, extB, prod, acc;
  logic [DATA_W:0]   shifted;
  logic              fits;
  logic [DATA_W-1:0] nextRem, nextQuo, finQuo, finRem, magA, magB;

  assign extA = {{DATA_W{ctl.isSigned & opA[DATA_W-1]}}, opA};
  assign extB = {{DATA_W{ctl.isSigned & opB[DATA_W-1]}}, opB};
  assign prod = extA * extB;
  assign acc  = {hiQ, loQ};

  assign magA = (ctl.isSigned && opA[DATA_W-1]) ? -opA : opA;
  assign magB = (ctl.isSigned && opB[DATA_W-1]) ? -opB : opB;

  // one restoring step
  assign shifted = {remQ, quoQ[DATA_W-1]};
  assign fits    = shifted >= {1'b0, dvsQ};
  assign nextRem = fits ? (shifted[DATA_W-1:0] - dvsQ) : shifted[DATA_W-1:0];
  assign nextQuo = {quoQ[DATA_W-2:0], fits};
  assign finQuo  = zeroQ ? '0 : (negQuoQ ? -nextQuo : nextQuo);
  assign finRem  = zeroQ ? '0 : (negRemQ ? -nextRem : nextRem);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiQ <= '0; loQ <= '0; remQ <= '0; quoQ <= '0; dvsQ <= '0; resQ <= '0;
      resVldQ <= 1'b0; negQuoQ <= 1'b0; negRemQ <= 1'b0; zeroQ <= 1'b0;
    end else begin
      resVldQ <= 1'b0;
      case (ctl.op)
        OP_RDHI: begin resQ <= hiQ; resVldQ <= 1'b1; end
        OP_RDLO: begin resQ <= loQ; resVldQ <= 1'b1; end
        OP_WRHI: hiQ <= opA;
        OP_WRLO: loQ <= opA;
        OP_MULT: {hiQ, loQ} <= prod;
        OP_MADD: {hiQ, loQ} <= acc + prod;
        OP_MSUB: {hiQ, loQ} <= acc - prod;
        OP_MUL3: begin resQ <= prod[DATA_W-1:0]; resVldQ <= 1'b1; end
        OP_DIV: begin
          remQ    <= '0;
          quoQ    <= magA;
          dvsQ    <= magB;
          zeroQ   <= (opB == '0);
          negRemQ <= ctl.isSigned && opA[DATA_W-1];
          negQuoQ <= ctl.isSigned && (opA[DATA_W-1] ^ opB[DATA_W-1]);
        end
        default: ;
      endcase
      if (ctl.divStep) begin
        remQ <= nextRem;
        quoQ <= nextQuo;
        if (ctl.divLast) begin
          hiQ <= finRem;
          loQ <= finQuo;
        end
      end
    end
  end

  assign resValid = resVldQ;
  assign result   = resQ;

  assert_mul3_keeps_hilo_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.op == OP_MUL3) |=> (hiQ == $past(hiQ) && loQ == $past(loQ)));
  assert_read_returns_half_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.op == OP_RDHI) |=> (resVldQ && resQ == $past(hiQ)));
  assert_zero_divisor_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.divLast && zeroQ) |=> (hiQ == '0 && loQ == '0));
  assert_rem_below_divisor_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.divLast && !zeroQ && !negRemQ && !negQuoQ) |=> (hiQ < dvsQ));
endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo
  import mdu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              opGroup,
  input  logic [5:0]        funct,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic              busy,
  output logic              done,
  output logic              resValid,
  output logic [DATA_W-1:0] result
);
  mduCtl_t ctl;

  mdu_ctrl #(.DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .opGroup(opGroup), .funct(funct),
    .ctl(ctl), .busy(busy), .done(done)
  );

  mdu_datapath #(.DATA_W(DATA_W)) uPath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .opA(opA), .opB(opB),
    .resValid(resValid), .result(result)
  );
endmodule

// File: tb/tb_muldiv_hilo.sv
module tb_muldiv_hilo;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, opGroup = 1'b0;
  logic [5:0] funct = '0;
  logic [31:0] opA = '0, opB = '0;
  logic busy, done, resValid;
  logic [31:0] result;

  int nChecks = 0, nFails = 0;
  logic [31:0] expHi = '0, expLo = '0;
  bit finished = 0;

  muldiv_hilo dut (.clk(clk), .rstN(rstN), .start(start), .opGroup(opGroup),
    .funct(funct), .opA(opA), .opB(opB), .busy(busy), .done(done),
    .resValid(resValid), .result(result));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mulModel(bit s, logic [31:0] a, logic [31:0] b);
    logic [63:0] ea = s ? {{32{a[31]}}, a} : {32'b0, a};
    logic [63:0] eb = s ? {{32{b[31]}}, b} : {32'b0, b};
    return ea * eb;
  endfunction

  function automatic logic [63:0] divModel(bit s, logic [31:0] a, logic [31:0] b);
    longint sa, sb, q, r;
    if (b == 0) return 64'd0;
    if (s) begin
      sa = longint'($signed(a)); sb = longint'($signed(b));
      q = sa / sb; r = sa % sb;
      return {r[31:0], q[31:0]};
    end
    return {a % b, a / b};
  endfunction

  // drive from a falling edge, return at the falling edge after the sampling rise
  task automatic issue(bit g, logic [5:0] f, logic [31:0] a, logic [31:0] b);
    opGroup = g; funct = f; opA = a; opB = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic readBack(string req);
    issue(0, 6'h10, 0, 0);
    check(resValid && result == expHi, req, {31'b0, resValid, result}, {32'd1, expHi});
    issue(0, 6'h12, 0, 0);
    check(resValid && result == expLo, req, {31'b0, resValid, result}, {32'd1, expLo});
  endtask

  task automatic runDiv(bit s, logic [31:0] a, logic [31:0] b);
    int n = 0;
    issue(0, s ? 6'h1A : 6'h1B, a, b);
    while (!done && n < 40) begin
      if (busy) n++;
      @(negedge clk);
    end
    check(n == 32 && !busy, "R7 busy length", 64'(n), 64'd32);
    {expHi, expLo} = divModel(s, a, b);
    @(negedge clk);
    check(!done, "R7 done single cycle", {63'b0, done}, 64'd0);
  endtask

  function automatic logic [31:0] pickOp();
    case ($urandom_range(0, 5))
      0: return 32'h0;
      1: return 32'h1;
      2: return 32'hFFFF_FFFF;
      3: return 32'h8000_0000;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b;
    logic [63:0] p;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(!busy && !done && !resValid, "R1 flags", {61'b0, busy, done, resValid}, 64'd0);
    readBack("R1 reset HI/LO");

    // R6 read pulse width
    issue(0, 6'h11, 32'hCAFE_0001, 0); expHi = 32'hCAFE_0001;   // R5 move to HI
    issue(0, 6'h13, 32'h1234_5678, 0); expLo = 32'h1234_5678;   // R5 move to LO
    issue(0, 6'h10, 0, 0);
    check(resValid && result == expHi, "R6 read HI", {32'b0, result}, {32'b0, expHi});
    @(negedge clk);
    check(!resValid, "R6 valid one cycle", {63'b0, resValid}, 64'd0);
    readBack("R5 moves");

    // R4 three-operand multiply
    issue(1, 6'h02, 32'hFFFF_FFFD, 32'h0000_0007);
    check(resValid && result == 32'hFFFF_FFEB, "R4 mul result", {32'b0, result}, 64'hFFFF_FFEB);
    readBack("R4 HI/LO unchanged");

    // R2 corner multiplies
    issue(0, 6'h18, 32'h8000_0000, 32'h8000_0000); {expHi, expLo} = 64'h4000_0000_0000_0000;
    readBack("R2 signed min*min");
    issue(0, 6'h19, 32'hFFFF_FFFF, 32'hFFFF_FFFF); {expHi, expLo} = 64'hFFFF_FFFE_0000_0001;
    readBack("R2 unsigned max*max");

    // R3 msub wrap below zero
    issue(0, 6'h11, 0, 0); issue(0, 6'h13, 0, 0); expHi = 0; expLo = 0;
    issue(1, 6'h05, 32'd3, 32'd5); {expHi, expLo} = 64'd0 - 64'd15;
    readBack("R3 msubu wrap");
    issue(1, 6'h00, 32'hFFFF_FFFF, 32'd15); {expHi, expLo} = {expHi, expLo} - 64'd15;
    readBack("R3 madd signed");

    // R8 signed divide cases
    runDiv(1, 32'hFFFF_FFF9, 32'd2);   readBack("R8 -7/2");
    runDiv(1, 32'd7, 32'hFFFF_FFFE);   readBack("R8 7/-2");
    runDiv(1, 32'h8000_0000, 32'hFFFF_FFFF); readBack("R8 min/-1");
    runDiv(0, 32'hFFFF_FFFF, 32'd10);  readBack("R7 unsigned divide");
    // R9 zero divisor
    runDiv(0, 32'h1234_5678, 32'd0);   readBack("R9 zero divisor");

    // R10 parked read and R11 ignored strobes during a divide
    issue(0, 6'h1B, 32'd100, 32'd7);
    issue(0, 6'h12, 0, 0);                 // parked read of LO
    check(!resValid, "R10 no early answer", {63'b0, resValid}, 64'd0);
    issue(0, 6'h11, 32'hDEAD_BEEF, 0);     // R11 ignored while busy/parked
    while (!done) @(negedge clk);
    check(!resValid, "R10 not at done", {63'b0, resValid}, 64'd0);
    @(negedge clk);
    check(resValid && result == 32'd14, "R10 parked read", {32'b0, result}, 64'd14);
    expHi = 32'd2; expLo = 32'd14;
    readBack("R11 write during busy ignored");

    // R11 undefined code
    issue(0, 6'h14, 32'h5555_5555, 32'h3);
    check(!resValid && !busy, "R11 undefined no response", {62'b0, resValid, busy}, 64'd0);
    issue(1, 6'h03, 32'h5555_5555, 32'h3);
    readBack("R11 undefined ignored");

    // random mix
    for (int i = 0; i < 200; i++) begin
      int k = $urandom_range(0, 8);
      a = pickOp(); b = pickOp();
      case (k)
        0, 1: begin issue(0, k == 0 ? 6'h18 : 6'h19, a, b);
                    {expHi, expLo} = mulModel(k == 0, a, b); readBack("R2 random"); end
        2, 3: begin issue(1, k == 2 ? 6'h00 : 6'h01, a, b);
                    {expHi, expLo} = {expHi, expLo} + mulModel(k == 2, a, b); readBack("R3 random add"); end
        4, 5: begin issue(1, k == 4 ? 6'h04 : 6'h05, a, b);
                    {expHi, expLo} = {expHi, expLo} - mulModel(k == 4, a, b); readBack("R3 random sub"); end
        6: begin issue(1, 6'h02, a, b); p = mulModel(1, a, b);
                 check(resValid && result == p[31:0], "R4 random", {32'b0, result}, {32'b0, p[31:0]}); end
        7: begin issue(0, a[0] ? 6'h11 : 6'h13, a, b);
                 if (a[0]) expHi = a; else expLo = a; readBack("R5 random"); end
        default: begin
          if ($urandom_range(0, 7) == 0) b = 0;
          runDiv(a[1], a, b); readBack("R8 random divide");
        end
      endcase
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule